// File: doc/BRIEF.md
# Two-Line Ping-Pong Pixel Buffer Controller

This block sits between a pixel source and a serial link packet engine. Two line
buffers hold the payload words of queued packets. While one buffer drains toward
the link, the pixel stream can fill the other. Software queues a packet by writing
a header that carries only its length in words. A header is accepted only while a
buffer it can use is free. A status flag tells software when no buffer is left, and
an interrupt fires whenever that flag changes state.

A packet shorter than one line buffer takes a single buffer. A longer packet, up to
twice the buffer size, takes both buffers joined into one double-length line. In
that case no second packet can be queued until the long packet has fully drained.
Pixels fill packets in header order. The drain side reads words in the same order
and can never read past the last word that was written.

Top module: `pingpong_line_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `irq_status` is 0, `irq` is 0 and `drn_valid` is 0.
- R2: A header of length 1 to LINE_WORDS-1 is split mode and takes one free buffer. `busy` is 1 exactly while both buffers are held. From the all-free state, a first split header leaves `busy` at 0 and a second split header sets it to 1 in the cycle after its write.
- R3: A header of length LINE_WORDS to 2*LINE_WORDS is joined mode. It holds both buffers, so `busy` is 1 from the cycle after its write until its last word has been read.
- R4: A header write is ignored, with no later effect on `busy`, `drn_valid` or the drained data, in any of these cases: `busy` is 1; the length is 0 or above 2*LINE_WORDS; the header is joined mode while one buffer is held.
- R5: Each word on `pix_data` with `pix_valid` high goes to the oldest queued packet that still lacks words. Such a word is dropped when no queued packet lacks words.
- R6: Draining returns packets in header order and the words of each packet in write order. `drn_valid` is 1 only when the next word has been written. `drn_last` is 1 while the final word of the head packet is presented. A read with `drn_valid` low has no effect.
- R7: Reading the last word of a packet frees its buffer or buffers, and `busy` is 0 in the next cycle.
- R8: `irq_status` becomes 1 one cycle after `busy` changes in either direction. A pulse on `irq_clr` (write one to clear) clears it unless a new change arrives in the same cycle.
- R9: `irq` equals `irq_status` while `irq_en` is 1 and is 0 while `irq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_wr | input | 1 | Header write strobe |
| hdr_len | input | 11 | Packet length in words |
| pix_valid | input | 1 | Pixel word strobe |
| pix_data | input | 32 | Pixel word |
| drn_rd | input | 1 | Drain side takes the presented word |
| drn_data | output | 32 | Presented drain word |
| drn_valid | output | 1 | Presented word is written and readable |
| drn_last | output | 1 | Presented word ends its packet |
| busy | output | 1 | No buffer free for a new header |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears `irq_status` |
| irq_status | output | 1 | Latched busy-change event |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with LINE_WORDS = 8, so `hdr_len` is 5 bits wide. With
this size, a split packet is at most 7 words and a joined packet 8 to 16 words, so
every allocation boundary can be reached in a few dozen cycles. Filling both
buffers, releasing them out of their bank order, rejecting a joined header while one
bank is held, and rejecting lengths of 0 and 17 all fit in short directed runs. The
same address split between the two banks runs at the default size of 768 words.

// File: rtl/pp_line_pkg.sv
// Shared types for the ping-pong line buffer controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package pp_line_pkg;

    // How a queued packet occupies the line buffers.
    typedef enum logic {
        PK_SPLIT  = 1'b0,   // one buffer
        PK_JOINED = 1'b1    // both buffers as one line
    } pk_kind_e;

    // Bank mask a split packet holds, given its bank index.
    function automatic logic [1:0] bank_mask(input logic bank);
        return bank ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/pp_line_store.sv
// Payload storage: two banks of LINE_WORDS words with one write and one read port.
// A flat address below LINE_WORDS selects bank 0; higher addresses select bank 1.
// In joined mode this makes the two banks one line of 2*LINE_WORDS words.
// Assumes: the read address is used only for written words (no read reset needed).
module pp_line_store #(
    parameter int LINE_WORDS = 768,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = $clog2(2*LINE_WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int OFS_W = (LINE_WORDS <= 2) ? 1 : $clog2(LINE_WORDS);

    logic              wr_hi, rd_hi;
    logic [OFS_W-1:0]  wr_ofs, rd_ofs;
    logic [DATA_W-1:0] bank_q [2];

    // Split flat addresses into a bank select and an in-bank offset.
    always_comb begin
        wr_hi  = (wr_addr >= ADDR_W'(LINE_WORDS));
        rd_hi  = (rd_addr >= ADDR_W'(LINE_WORDS));
        wr_ofs = OFS_W'(wr_hi ? (wr_addr - ADDR_W'(LINE_WORDS)) : wr_addr);
        rd_ofs = OFS_W'(rd_hi ? (rd_addr - ADDR_W'(LINE_WORDS)) : rd_addr);
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [DATA_W-1:0] mem [LINE_WORDS];

        // Store an incoming word into this bank when it is addressed.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_hi == 1'(g))) begin
                mem[wr_ofs] <= wr_data;
            end
        end

        assign bank_q[g] = mem[rd_ofs];
    end

    assign rd_data = rd_hi ? bank_q[1] : bank_q[0];

endmodule

// File: rtl/pp_alloc_queue.sv
// Header queue and buffer allocator. It holds up to two packet descriptors in
// header order and tracks which banks are held. It steers pixel writes into the
// oldest packet that still lacks words, and presents drain reads from the head
// packet. A bank is released when the last word of its packet is read.
// Assumes: at most two packets are queued (one per bank), or one joined packet.
module pp_alloc_queue
    import pp_line_pkg::*;
#(
    parameter int LINE_WORDS = 768,
    parameter int LEN_W      = $clog2(2*LINE_WORDS+1),
    parameter int ADDR_W     = $clog2(2*LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_wr,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic              pix_valid,
    input  logic              drn_rd,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              drn_valid,
    output logic              drn_last,
    output logic              busy
);
    logic [LEN_W-1:0] slot_len  [2];
    pk_kind_e         slot_kind [2];
    logic             slot_bank [2];
    logic             head;
    logic [1:0]       count;
    logic [1:0]       fill_ofs;
    logic [LEN_W-1:0] fill_cnt;
    logic [LEN_W-1:0] drain_cnt;
    logic [1:0]       used;

    logic             len_ok, hdr_joined, accept, new_bank, tail;
    logic             fill_slot, fill_active, fill_done, rd_fire, pop;
    logic [ADDR_W-1:0] fill_base, drain_base;
    logic [1:0]       free_mask, alloc_mask;

    // Decide header acceptance and where the new packet lands.
    always_comb begin
        len_ok     = (hdr_len != '0) && (hdr_len <= LEN_W'(2*LINE_WORDS));
        hdr_joined = (hdr_len >= LEN_W'(LINE_WORDS));
        accept     = hdr_wr && len_ok && (hdr_joined ? (used == 2'b00) : (used != 2'b11));
        new_bank   = used[0];
        tail       = head ^ count[0];
        alloc_mask = !accept ? 2'b00 : (hdr_joined ? 2'b11 : bank_mask(new_bank));
    end

    // Steer pixel writes to the oldest packet that still lacks words.
    always_comb begin
        fill_slot   = head ^ fill_ofs[0];
        fill_active = (fill_ofs < count);
        wr_en       = pix_valid && fill_active;
        fill_done   = wr_en && (fill_cnt == slot_len[fill_slot] - LEN_W'(1));
        fill_base   = (slot_kind[fill_slot] == PK_SPLIT && slot_bank[fill_slot])
                      ? ADDR_W'(LINE_WORDS) : '0;
        wr_addr     = fill_base + ADDR_W'(fill_cnt);
    end

    // Present the head packet to the drain side, never past the written words.
    always_comb begin
        drn_valid  = (count != 2'd0) && ((fill_ofs != 2'd0) || (drain_cnt < fill_cnt));
        drn_last   = drn_valid && (drain_cnt == slot_len[head] - LEN_W'(1));
        rd_fire    = drn_rd && drn_valid;
        pop        = rd_fire && drn_last;
        drain_base = (slot_kind[head] == PK_SPLIT && slot_bank[head])
                     ? ADDR_W'(LINE_WORDS) : '0;
        rd_addr    = drain_base + ADDR_W'(drain_cnt);
        free_mask  = !pop ? 2'b00 :
                     ((slot_kind[head] == PK_JOINED) ? 2'b11 : bank_mask(slot_bank[head]));
    end

    assign busy = (used == 2'b11);

    // Update descriptors, bank ownership and the fill and drain positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                slot_len[i]  <= '0;
                slot_kind[i] <= PK_SPLIT;
                slot_bank[i] <= 1'b0;
            end
            head      <= 1'b0;
            count     <= 2'd0;
            fill_ofs  <= 2'd0;
            fill_cnt  <= '0;
            drain_cnt <= '0;
            used      <= 2'b00;
        end else begin
            if (accept) begin
                slot_len[tail]  <= hdr_len;
                slot_kind[tail] <= hdr_joined ? PK_JOINED : PK_SPLIT;
                slot_bank[tail] <= hdr_joined ? 1'b0 : new_bank;
            end
            used     <= (used & ~free_mask) | alloc_mask;
            count    <= count + {1'b0, accept} - {1'b0, pop};
            head     <= head ^ pop;
            fill_ofs <= fill_ofs + {1'b0, fill_done} - {1'b0, pop};
            if (fill_done) begin
                fill_cnt <= '0;
            end else if (wr_en) begin
                fill_cnt <= fill_cnt + LEN_W'(1);
            end
            if (pop) begin
                drain_cnt <= '0;
            end else if (rd_fire) begin
                drain_cnt <= drain_cnt + LEN_W'(1);
            end
        end
    end

    // R2: never more than two packets queued.
    p_count_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= 2'd2);

    // R3: a joined packet is always alone in the queue.
    p_joined_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count != 2'd0 && slot_kind[head] == PK_JOINED) |-> (count == 2'd1));

    // R4: a header written while busy does not enter the queue.
    p_busy_hdr_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hdr_wr && !pop) |=> (count == $past(count)));

    // R6: a read without a valid word leaves the drain position alone.
    p_rd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_rd && !drn_valid) |=> $stable(drain_cnt));

    // R7: finishing a packet always leaves a bank free.
    p_free_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !busy);

endmodule

// File: rtl/pp_busy_irq.sv
// Busy-change event latch. It records any change of the busy flag in a sticky
// status bit that is cleared by a one-cycle pulse, and gates it with an enable.
// Assumes: busy comes from a register, so one sample per clock sees every change.
module pp_busy_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic irq_en,
    input  logic irq_clr,
    output logic irq_status,
    output logic irq
);
    logic busy_q;

    // Keep the last busy value and latch a change event; a change beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            irq_status <= 1'b0;
        end else begin
            busy_q <= busy;
            if (busy != busy_q) begin
                irq_status <= 1'b1;
            end else if (irq_clr) begin
                irq_status <= 1'b0;
            end
        end
    end

    assign irq = irq_status & irq_en;

    // R8: a seen change of busy leaves the status set.
    p_change_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy != busy_q) |=> irq_status);

    // R8: a clear with no competing change empties the status.
    p_clear_works_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && busy == busy_q) |=> !irq_status);

endmodule

// File: rtl/pingpong_line_ctrl.sv
// Top of the two-line ping-pong pixel buffer controller. It joins the allocator
// queue, the two-bank payload store and the busy-change interrupt latch.
// Assumes: software writes headers only while busy is 0. Other writes are dropped.
module pingpong_line_ctrl #(
    parameter int  LINE_WORDS = 768,
    parameter int  DATA_W     = 32,
    localparam int LEN_W      = $clog2(2*LINE_WORDS+1),
    localparam int ADDR_W     = $clog2(2*LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_wr,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              drn_rd,
    output logic [DATA_W-1:0] drn_data,
    output logic              drn_valid,
    output logic              drn_last,
    output logic              busy,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              irq_status,
    output logic              irq
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    pp_alloc_queue #(
        .LINE_WORDS (LINE_WORDS),
        .LEN_W      (LEN_W),
        .ADDR_W     (ADDR_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_wr    (hdr_wr),
        .hdr_len   (hdr_len),
        .pix_valid (pix_valid),
        .drn_rd    (drn_rd),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .drn_valid (drn_valid),
        .drn_last  (drn_last),
        .busy      (busy)
    );

    pp_line_store #(
        .LINE_WORDS (LINE_WORDS),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (pix_data),
        .rd_addr (rd_addr),
        .rd_data (drn_data)
    );

    pp_busy_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .irq_en     (irq_en),
        .irq_clr    (irq_clr),
        .irq_status (irq_status),
        .irq        (irq)
    );

endmodule

// File: tb/pingpong_line_ctrl_tb_top.sv
// Bench for the ping-pong line controller with LINE_WORDS = 8.
module pingpong_line_ctrl_tb_top;
    localparam int LW    = 8;
    localparam int DW    = 32;
    localparam int LEN_W = $clog2(2*LW+1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hdr_wr = 1'b0;
    logic [LEN_W-1:0] hdr_len = '0;
    logic             pix_valid = 1'b0;
    logic [DW-1:0]    pix_data = '0;
    logic             drn_rd = 1'b0;
    logic [DW-1:0]    drn_data;
    logic             drn_valid, drn_last, busy;
    logic             irq_en = 1'b0;
    logic             irq_clr = 1'b0;
    logic             irq_status, irq;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] exp_q [256];
    int wr_p = 0;
    int rd_p = 0;
    logic [DW-1:0] seq = 32'hA500_0000;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pingpong_line_ctrl #(.LINE_WORDS(LW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hdr_wr(hdr_wr), .hdr_len(hdr_len),
        .pix_valid(pix_valid), .pix_data(pix_data), .drn_rd(drn_rd),
        .drn_data(drn_data), .drn_valid(drn_valid), .drn_last(drn_last),
        .busy(busy), .irq_en(irq_en), .irq_clr(irq_clr),
        .irq_status(irq_status), .irq(irq)
    );

    // Step table: header length (0 = none), words pushed, words drained,
    // expected busy, expected irq_status, clear status after the check.
    localparam logic [26:0] VEC [9] = '{
        {8'd5,  8'd0,  8'd0,  1'b0, 1'b0, 1'b0},
        {8'd3,  8'd0,  8'd0,  1'b1, 1'b1, 1'b1},
        {8'd0,  8'd8,  8'd5,  1'b0, 1'b1, 1'b1},
        {8'd0,  8'd0,  8'd3,  1'b0, 1'b0, 1'b0},
        {8'd12, 8'd0,  8'd0,  1'b1, 1'b1, 1'b1},
        {8'd0,  8'd12, 8'd12, 1'b0, 1'b1, 1'b1},
        {8'd7,  8'd0,  8'd0,  1'b0, 1'b0, 1'b0},
        {8'd0,  8'd7,  8'd4,  1'b0, 1'b0, 1'b0},
        {8'd0,  8'd0,  8'd3,  1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hdr(input int len);
        @(negedge clk);
        hdr_wr  = 1'b1;
        hdr_len = LEN_W'(len);
        @(negedge clk);
        hdr_wr  = 1'b0;
    endtask

    task automatic push(input int n, input bit keep);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = 1'b1;
            pix_data  = seq;
            if (keep) begin
                exp_q[wr_p] = seq;
                wr_p++;
            end
            seq++;
        end
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R6 drn_valid", {31'b0, drn_valid}, 32'd1);
            chk("R6 drn_data order", drn_data, exp_q[rd_p]);
            rd_p++;
            drn_rd = 1'b1;
            @(negedge clk);
            drn_rd = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic clr();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 irq_status", {31'b0, irq_status}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 drn_valid", {31'b0, drn_valid}, 32'd0);

        // Table walk: R2 split queueing, R3 joined line, R7 release, R8 events.
        irq_en = 1'b1;
        for (int s = 0; s < 9; s++) begin
            if (VEC[s][26:19] != 8'd0) hdr(int'(VEC[s][26:19]));
            if (VEC[s][18:11] != 8'd0) push(int'(VEC[s][18:11]), 1'b1);
            if (VEC[s][10:3]  != 8'd0) drain(int'(VEC[s][10:3]));
            settle();
            chk("R2 R3 R7 busy step", {31'b0, busy}, {31'b0, VEC[s][2]});
            chk("R8 irq_status step", {31'b0, irq_status}, {31'b0, VEC[s][1]});
            chk("R9 irq step", {31'b0, irq}, {31'b0, VEC[s][1]});
            if (VEC[s][0]) clr();
        end

        // R4: lengths 0 and 17 are ignored
        hdr(0);
        hdr(17);
        push(1, 1'b0);
        settle();
        chk("R4 bad length busy", {31'b0, busy}, 32'd0);
        chk("R4 bad length drn_valid", {31'b0, drn_valid}, 32'd0);

        // R4: joined header while one bank is held is ignored
        hdr(4);
        hdr(10);
        settle();
        chk("R4 joined rejected busy", {31'b0, busy}, 32'd0);
        push(4, 1'b1);
        push(1, 1'b0);
        drain(4);
        settle();
        chk("R4 joined rejected drn_valid", {31'b0, drn_valid}, 32'd0);

        // R4: header while busy is ignored
        hdr(3);
        hdr(3);
        settle();
        chk("R2 second split header busy", {31'b0, busy}, 32'd1);
        hdr(3);
        push(6, 1'b1);
        push(1, 1'b0);
        drain(6);
        settle();
        chk("R4 busy header drn_valid", {31'b0, drn_valid}, 32'd0);
        chk("R7 busy after drain", {31'b0, busy}, 32'd0);

        // R5: pixels with no packet waiting are dropped
        push(2, 1'b0);
        hdr(2);
        push(2, 1'b1);
        drain(2);
        settle();
        chk("R5 drop drn_valid", {31'b0, drn_valid}, 32'd0);

        // R6: drain follows header order, not bank order
        hdr(2);
        hdr(3);
        push(5, 1'b1);
        drain(2);
        settle();
        chk("R7 one bank freed", {31'b0, busy}, 32'd0);
        hdr(2);
        settle();
        chk("R2 refill busy", {31'b0, busy}, 32'd1);
        push(2, 1'b1);
        drain(5);

        // R6: drain waits for written words; drn_last marks the end
        hdr(4);
        push(1, 1'b1);
        @(negedge clk);
        chk("R6 first word valid", {31'b0, drn_valid}, 32'd1);
        chk("R6 not last", {31'b0, drn_last}, 32'd0);
        drain(1);
        settle();
        chk("R6 wait for write", {31'b0, drn_valid}, 32'd0);
        push(3, 1'b1);
        drain(2);
        @(negedge clk);
        chk("R6 drn_last final", {31'b0, drn_last}, 32'd1);
        drain(1);
        settle();

        // R9: enable gates the interrupt, R8 status still records
        clr();
        irq_en = 1'b0;
        hdr(3);
        hdr(3);
        settle();
        chk("R8 status with enable off", {31'b0, irq_status}, 32'd1);
        chk("R9 irq masked", {31'b0, irq}, 32'd0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R9 irq unmasked", {31'b0, irq}, 32'd1);
        push(6, 1'b1);
        drain(6);
        settle();
        clr();
        settle();
        chk("R8 cleared", {31'b0, irq_status}, 32'd0);

        summary();
        $finish;
    end

endmodule